// File: doc/BRIEF.md
# Chip-Select Access Protection Checker

The block looks at every bus access and finds the chip-select channel whose address window contains it. It then checks that channel's protection options against the attributes of the access. An access that passes drives the winning channel's external chip enable for one cycle. An access that breaks a rule leaves every chip enable low and raises an internal transfer-error pulse in that same cycle instead.

Each channel is programmed with a base address, a block-size mask, a two-bit mode and three option bits: supervisor-only, data-only and write-lock. A parameter marks which channels have address-decoding protection hardware. The other channels ignore their option bits and can never raise an error.

The result is held in a three-state machine. `ST_IDLE` means no channel was hit. `ST_GRANT` means a permitted hit, and the registered one-hot channel select drives the chip enables. `ST_FAULT` means a violating hit, which drives the error output. The next state depends only on the access presented in the current cycle. The transitions are: any state to `ST_GRANT` on a permitted hit, any state to `ST_FAULT` on a violating hit, any state to `ST_IDLE` on no hit, and reset to `ST_IDLE`.

Top module: `cs_guard`

## Requirements
- R1: A channel is hit when `acc_valid` is 1, its mode is not 0, and `(acc_addr & mask) == base`. A permitted hit raises exactly that channel's `cs_en` bit in the cycle after the access is sampled. `cs_en` is always one-hot or zero.
- R2: When several channels are hit, the lowest-numbered one wins. Only its chip enable and its options are used.
- R3: With `acc_valid` low, or with no channel hit, the next cycle has `cs_en` all zero and `bus_err` low.
- R4: Option bit 0 (supervisor-only) set, together with `acc_super`=0 (user) and `acc_instr`=0 (data), is a violation. An instruction fetch (`acc_instr`=1) is never flagged by this rule.
- R5: Option bit 1 (data-only) set, together with `acc_instr`=1 (instruction access), is a violation.
- R6: Option bit 2 (write-lock) set, together with `acc_write`=1, is a violation. Reads are allowed.
- R7: Option bits take effect only in mode 1 (chip enable) or mode 2 (sub-block). Mode 3 (plain strobe) hits but ignores the options. Mode 0 (off) never hits.
- R8: A channel whose bit in `PROT_MASK` is 0 never raises `bus_err`, whatever its option bits are.
- R9: A violation raises `bus_err` for one cycle, in the cycle the chip enable would have risen, and keeps all `cs_en` bits low in that cycle.
- R10: The synchronous active-high `rst` clears both outputs. While `rst` is high, no chip enable and no error is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_super | input | 1 | 1 = supervisor, 0 = user |
| acc_instr | input | 1 | 1 = instruction, 0 = data |
| ch_base | input | NUM_CH*ADDR_W | Per-channel base address, channel 0 in the low bits |
| ch_mask | input | NUM_CH*ADDR_W | Per-channel block-size mask (1 = bit compared) |
| ch_mode | input | NUM_CH*2 | Per-channel mode: 0 off, 1 chip enable, 2 sub-block, 3 strobe |
| ch_opt | input | NUM_CH*3 | Per-channel options: bit0 supervisor-only, bit1 data-only, bit2 write-lock |
| cs_en | output | NUM_CH | Registered chip enables |
| bus_err | output | 1 | Registered transfer-error pulse |

## Verification
A wrong state register or channel-select register shows at the ports one cycle after the access. It appears as an enable on the wrong channel, an enable together with an error, or an error where an enable belongs. The design has no memory beyond that one stage, so every fault appears on the very next cycle and never later. The bench sweeps every address against every attribute combination, with every mode and option setting applied to a layout of overlapping windows. This exposes priority, gating and rule faults immediately.

// File: rtl/cs_guard_pkg.sv
package cs_guard_pkg;

    localparam int MODE_W = 2;
    localparam int OPT_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 2'd0,
        MODE_CE     = 2'd1,
        MODE_SUB    = 2'd2,
        MODE_STROBE = 2'd3
    } cs_mode_e;

    typedef struct packed {
        logic wr_lock;
        logic data_only;
        logic sup_only;
    } cs_opt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_FAULT = 2'd2
    } grd_state_e;

endpackage

// File: rtl/cs_guard_match.sv
module cs_guard_match
    import cs_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic [MODE_W-1:0] mode,
    output logic              hit
);

    cs_mode_e mode_e;
    logic     in_window;

    always_comb begin
        mode_e    = cs_mode_e'(mode);
        in_window = ((addr & mask) == base);
        hit       = valid && in_window && (mode_e != MODE_OFF);
    end

endmodule

// File: rtl/cs_guard_arbiter.sv
module cs_guard_arbiter #(
    parameter int NUM_CH = 4,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] grant,
    output logic [IDX_W-1:0]  idx,
    output logic              any
);

    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cs_guard_rules.sv
module cs_guard_rules
    import cs_guard_pkg::*;
(
    input  cs_mode_e mode,
    input  cs_opt_t  opt,
    input  logic     prot_hw,
    input  logic     is_write,
    input  logic     is_super,
    input  logic     is_instr,
    output logic     viol
);

    logic armed;
    logic sup_bad;
    logic data_bad;
    logic wr_bad;

    always_comb begin
        unique case (mode)
            MODE_CE,
            MODE_SUB:    armed = prot_hw;
            MODE_STROBE,
            MODE_OFF:    armed = 1'b0;
            default:     armed = 1'b0;
        endcase
        sup_bad  = opt.sup_only  && !is_super && !is_instr;
        data_bad = opt.data_only && is_instr;
        wr_bad   = opt.wr_lock   && is_write;
        viol     = armed && (sup_bad || data_bad || wr_bad);
    end

endmodule

// File: rtl/cs_guard.sv
module cs_guard
    import cs_guard_pkg::*;
#(
    parameter int              NUM_CH    = 4,
    parameter int              ADDR_W    = 8,
    parameter logic [NUM_CH-1:0] PROT_MASK = 4'b0111
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       acc_valid,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic                       acc_write,
    input  logic                       acc_super,
    input  logic                       acc_instr,
    input  logic [NUM_CH*ADDR_W-1:0]   ch_base,
    input  logic [NUM_CH*ADDR_W-1:0]   ch_mask,
    input  logic [NUM_CH*MODE_W-1:0]   ch_mode,
    input  logic [NUM_CH*OPT_W-1:0]    ch_opt,
    output logic [NUM_CH-1:0]          cs_en,
    output logic                       bus_err
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] take;
    logic [IDX_W-1:0]  win;
    logic              any_hit;
    cs_mode_e          win_mode;
    cs_opt_t           win_opt;
    logic              win_prot;
    logic              viol;

    grd_state_e        state_q;
    grd_state_e        state_d;
    logic [NUM_CH-1:0] sel_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_match
        cs_guard_match #(.ADDR_W(ADDR_W)) u_match (
            .valid (acc_valid),
            .addr  (acc_addr),
            .base  (ch_base[g*ADDR_W +: ADDR_W]),
            .mask  (ch_mask[g*ADDR_W +: ADDR_W]),
            .mode  (ch_mode[g*MODE_W +: MODE_W]),
            .hit   (hit[g])
        );
    end

    cs_guard_arbiter #(.NUM_CH(NUM_CH)) u_arb (
        .req   (hit),
        .grant (take),
        .idx   (win),
        .any   (any_hit)
    );

    always_comb begin
        win_mode = cs_mode_e'(ch_mode[win*MODE_W +: MODE_W]);
        win_opt  = cs_opt_t'(ch_opt[win*OPT_W +: OPT_W]);
        win_prot = PROT_MASK[win];
    end

    cs_guard_rules u_rules (
        .mode     (win_mode),
        .opt      (win_opt),
        .prot_hw  (win_prot),
        .is_write (acc_write),
        .is_super (acc_super),
        .is_instr (acc_instr),
        .viol     (viol)
    );

    // Next state: decided by the access of this cycle only
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_FAULT: begin
                if (!any_hit)  state_d = ST_IDLE;
                else if (viol) state_d = ST_FAULT;
                else           state_d = ST_GRANT;
            end
            default:           state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= take;
        end
    end

    // Outputs
    always_comb begin
        cs_en   = '0;
        bus_err = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_GRANT: cs_en   = sel_q;
            ST_FAULT: bus_err = 1'b1;
            default:  ;
        endcase
        if (rst) begin
            cs_en   = '0;
            bus_err = 1'b0;
        end
    end

endmodule

// File: rtl/cs_guard_chk.sv
module cs_guard_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter logic PROT0 = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              acc_super,
    input logic              acc_instr,
    input logic [ADDR_W-1:0] base0,
    input logic [ADDR_W-1:0] mask0,
    input logic [1:0]        mode0,
    input logic [2:0]        opt0,
    input logic [NUM_CH-1:0] cs_en,
    input logic              bus_err
);

    logic hit0;
    logic armed0;
    assign hit0   = acc_valid && ((acc_addr & mask0) == base0) && (mode0 != 2'd0);
    assign armed0 = PROT0 && (mode0 == 2'd1 || mode0 == 2'd2);

    AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_en)); // R1

    AST_CH0_GRANT: assert property (@(posedge clk) disable iff (rst)
        (hit0 && !armed0) |=> (cs_en[0] && !bus_err)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (cs_en == '0 && !bus_err)); // R3

    AST_SUP_USER: assert property (@(posedge clk) disable iff (rst)
        (hit0 && armed0 && opt0[0] && !acc_super && !acc_instr) |=> bus_err); // R4

    AST_DATA_FETCH: assert property (@(posedge clk) disable iff (rst)
        (hit0 && armed0 && opt0[1] && acc_instr) |=> bus_err); // R5

    AST_WRITE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (hit0 && armed0 && opt0[2] && acc_write) |=> bus_err); // R6

    AST_STROBE_FREE: assert property (@(posedge clk) disable iff (rst)
        (hit0 && mode0 == 2'd3) |=> !bus_err); // R7

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (cs_en == '0)); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (cs_en == '0 && !bus_err)); // R10

endmodule

bind cs_guard cs_guard_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .PROT0  (PROT_MASK[0])
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_write (acc_write),
    .acc_super (acc_super),
    .acc_instr (acc_instr),
    .base0     (ch_base[ADDR_W-1:0]),
    .mask0     (ch_mask[ADDR_W-1:0]),
    .mode0     (ch_mode[1:0]),
    .opt0      (ch_opt[2:0]),
    .cs_en     (cs_en),
    .bus_err   (bus_err)
);

// File: tb/cs_guard_bench.sv
module cs_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           acc_valid = 1'b0;
    logic [AW-1:0]  acc_addr  = '0;
    logic           acc_write = 1'b0;
    logic           acc_super = 1'b0;
    logic           acc_instr = 1'b0;
    logic [NCH*AW-1:0] ch_base;
    logic [NCH*AW-1:0] ch_mask;
    logic [NCH*2-1:0]  ch_mode = '0;
    logic [NCH*3-1:0]  ch_opt  = '0;
    logic [NCH-1:0] cs_en;
    logic           bus_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // ch0 0x00-0x3F, ch1 0x20-0x3F, ch2 0x80-0xBF, ch3 0x80-0xFF (no protection)
    assign ch_base = {8'h80, 8'h80, 8'h20, 8'h00};
    assign ch_mask = {8'h80, 8'hC0, 8'hE0, 8'hC0};

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_guard u_cs_guard (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_super(acc_super), .acc_instr(acc_instr),
        .ch_base(ch_base), .ch_mask(ch_mask), .ch_mode(ch_mode), .ch_opt(ch_opt),
        .cs_en(cs_en), .bus_err(bus_err)
    );

    function automatic void model(input logic v, input logic [7:0] a,
                                  input logic w, input logic s, input logic i,
                                  input int m, input logic [2:0] o,
                                  output logic [3:0] en, output logic err,
                                  output string tag);
        int  win   = -1;
        logic prot, sb, db, wb;
        for (int c = 0; c < 4; c++) begin
            if (win < 0 && v && m != 0 && ((a & ch_mask[c*8 +: 8]) == ch_base[c*8 +: 8]))
                win = c;
        end
        prot = (win >= 0) && (win != 3) && (m == 1 || m == 2);
        sb = o[0] && !s && !i;
        db = o[1] && i;
        wb = o[2] && w;
        err = prot && (sb || db || wb);
        en  = (win >= 0 && !err) ? 4'(1 << win) : 4'b0;
        if (err)                         tag = sb ? "R4" : (db ? "R5" : "R6");
        else if (m == 0 && v)            tag = "R7";
        else if (win < 0)                tag = "R3";
        else if (m == 3 && o != 0)       tag = "R7";
        else if (win == 3 && o != 0)     tag = "R8";
        else if ((a >= 8'h20 && a <= 8'h3F) || (a >= 8'h80 && a <= 8'hBF)) tag = "R2";
        else                             tag = "R1";
    endfunction

    task automatic check(input string tag, input logic [3:0] ex_en, input logic ex_err);
        checks++;
        if (cs_en !== ex_en || bus_err !== ex_err) begin
            fails++;
            $display("FAIL %s addr=%h actual en=%b err=%b expected en=%b err=%b",
                     tag, acc_addr, cs_en, bus_err, ex_en, ex_err);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] p_en;
        logic       p_err;
        string      p_tag;
        bit         have = 1'b0;

        // R10: reset holds outputs low even with a hitting access present
        ch_mode   = {4{2'd1}};
        acc_valid = 1'b1;
        acc_addr  = 8'h10;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10", 4'b0, 1'b0);
        end
        @(negedge clk);
        rst = 1'b0;
        acc_valid = 1'b0;
        @(negedge clk);
        check("R10", 4'b0, 1'b0);

        for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 8; o++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int at = 0; at < 8; at++) begin
                        @(negedge clk);
                        if (have) begin
                            check(p_tag, p_en, p_err);
                            if (p_err) begin
                                checks++;
                                if (cs_en !== 4'b0) begin
                                    fails++;
                                    $display("FAIL R9 actual en=%b expected en=0000 with error", cs_en);
                                end
                            end
                        end
                        ch_mode   = {4{2'(m)}};
                        ch_opt    = {4{3'(o)}};
                        acc_addr  = 8'(a);
                        acc_write = at[0];
                        acc_super = at[1];
                        acc_instr = at[2];
                        acc_valid = (acc_addr[3:0] != 4'hF);
                        model(acc_valid, acc_addr, acc_write, acc_super, acc_instr,
                              m, 3'(o), p_en, p_err, p_tag);
                        have = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
        check(p_tag, p_en, p_err);
        acc_valid = 1'b0;
        @(negedge clk);
        check("R3", 4'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule